// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Generation

This block turns bytes into an asynchronous serial bit stream on a single output line, and it can also hold that line low on purpose to signal a break to the far end. A one-entry holding register accepts a byte whenever it is free. A shift engine then sends the byte as a frame. Each bit period of the frame lasts from one pulse of the bit-rate enable input to the next. The rate generator itself sits outside the block.

A break is requested with a one-cycle pulse on the start-break input. It travels through the holding register like an ordinary character. Once it reaches the line, every field of its frame is driven low, and further break frames follow back to back for as long as the request stands. A pulse on the stop-break input withdraws the request. The frame on the line still completes. The line then stays high for a recovery period before any queued character may start, so the receiver reliably sees the break end.

Top module: `uart_brk_tx`

## Requirements
- R1: After a synchronous reset, `txd` is 1 (idle line), `txrdy` is 1 and `txempty` is 1.
- R2: A `thr_wr` pulse while `txrdy` is 1 captures `thr_data`. `txrdy` and `txempty` are 0 from the next cycle on.
- R3: A normal frame consists of a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. Each bit lasts exactly one bit period, measured between consecutive `bit_en` pulses.
- R4: When `par_en` is 1, an even parity bit (the XOR of the 8 data bits) is placed between the last data bit and the stop bit.
- R5: After the stop bit, the line stays 1 for `tg_len` bit periods (time guard). A queued character then starts in the very next bit period.
- R6: A `thr_wr` pulse while `txrdy` is 0 is discarded, and the byte never appears on the line.
- R7: A `brk_start` pulse is accepted only while `txrdy` is 1. Otherwise it has no effect, and no break appears on the line.
- R8: Accepting a break request makes both `txrdy` and `txempty` 0 from the next cycle on.
- R9: A break frame has the same length as a normal frame (start, data, optional parity, stop, time guard), and `txd` is 0 in every one of its bit periods. Break frames repeat back to back with no high bit between them until `brk_stop` arrives.
- R10: After `brk_stop`, the break frame in progress completes and no further break frame begins. The line then stays 1 for exactly max(`tg_len`, 12) bit periods before a queued character starts.
- R11: A byte written after a break request is accepted but before the break frame has started is discarded.
- R12: `txempty` is 1 only when the holding register is empty and the line is idle. It stays 0 while a frame is being sent and during the recovery period after a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle pulse marking each bit-period boundary |
| thr_wr | input | 1 | Holding-register write strobe |
| thr_data | input | 8 | Byte to transmit |
| par_en | input | 1 | Insert an even parity bit when 1 |
| tg_len | input | 8 | Time-guard length in bit periods (0 = none) |
| brk_start | input | 1 | Start-break request pulse |
| brk_stop | input | 1 | Stop-break request pulse |
| txd | output | 1 | Serial line, idle high |
| txrdy | output | 1 | Holding register free |
| txempty | output | 1 | Nothing pending and line idle |

## Verification
The bench records the line value once per bit period. It then measures the break as a run of zeros, which must be a whole number of break frames of the configured length; a design that dropped the line high between chained breaks, or cut a frame short on stop-break, would break that run. The high gap after the break is measured exactly, with a time guard both below and above 12, so a design that used only the guard or only the fixed floor gets the wrong length. A byte written in the cycle after a break is accepted must never reach the line, and `txempty` must stay low during the recovery gap, where a design that keyed it only on the shifter would raise it early. Back-to-back frames with a guard check that the next start bit falls in exactly the right period, and that writes and break requests made while the register is full leave no trace on the line.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_GUARD,
    ST_RECOV
  } tx_state_e;

  // Length of the forced idle-high period after a break ends
  function automatic int unsigned gap_len(int unsigned guard, int unsigned floor_n);
    return (guard > floor_n) ? guard : floor_n;
  endfunction

  // Number of bit periods in one frame, break or normal
  function automatic int unsigned frame_len(int unsigned data_bits, bit par, int unsigned guard);
    return 1 + data_bits + (par ? 1 : 0) + 1 + guard;
  endfunction

endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_data,
  input  logic              brk_start,
  input  logic              brk_stop,
  input  logic              take,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_brk,
  output logic              brk_req
);

  // Named events, also used by the assertions
  logic acc_brk;
  logic acc_chr;

  assign acc_brk = !hold_valid && brk_start;
  assign acc_chr = !hold_valid && thr_wr && !brk_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      hold_brk   <= 1'b0;
    end else if (take) begin
      hold_valid <= 1'b0;
    end else if (acc_brk) begin
      hold_valid <= 1'b1;
      hold_data  <= '0;
      hold_brk   <= 1'b1;
    end else if (acc_chr) begin
      hold_valid <= 1'b1;
      hold_data  <= thr_data;
      hold_brk   <= 1'b0;
    end
  end

  // A stop-break request wins over a start-break request in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
    end else if (brk_stop) begin
      brk_req <= 1'b0;
    end else if (acc_brk) begin
      brk_req <= 1'b1;
    end
  end

  p_brk_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_brk && !brk_stop) |=> (hold_valid && hold_brk && brk_req));

  p_full_ignores_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && !take) |=> (hold_valid && $stable(hold_data) && $stable(hold_brk)));

  p_chr_accept_r2: assert property (@(posedge clk) disable iff (rst)
    acc_chr |=> (hold_valid && !hold_brk && hold_data == $past(thr_data)));

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (rst)
    brk_stop |=> !brk_req);

endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift
  import uart_brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TG_W    = 8,
  parameter int MIN_GAP = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              par_en,
  input  logic [TG_W-1:0]   tg_len,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_brk,
  input  logic              brk_req,
  output logic              take,
  output logic              txd,
  output logic              busy,
  output logic              in_recov,
  output logic              in_brk
);

  localparam int BASE_W = (TG_W > $clog2(MIN_GAP + 1)) ? TG_W : $clog2(MIN_GAP + 1);
  localparam int CNT_W  = ((BASE_W > $clog2(DATA_W + 1)) ? BASE_W : $clog2(DATA_W + 1)) + 1;

  tx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              par_q;
  logic              cur_brk;

  logic [CNT_W-1:0]  tg_ext;
  logic [CNT_W-1:0]  gap_ext;

  // Named events
  logic frame_end;
  logic recov_end;
  logic idle_go;
  logic brk_again;
  logic to_recov;
  logic data_last;

  assign tg_ext  = CNT_W'(tg_len);
  assign gap_ext = CNT_W'(gap_len(int'(tg_len), MIN_GAP));

  assign data_last = (st == ST_DATA) && (cnt == CNT_W'(DATA_W - 1));
  assign frame_end = bit_en &&
                     (((st == ST_STOP) && (tg_ext == '0)) ||
                      ((st == ST_GUARD) && (cnt == tg_ext - CNT_W'(1))));
  assign recov_end = bit_en && (st == ST_RECOV) && (cnt == gap_ext - CNT_W'(1));
  assign idle_go   = bit_en && (st == ST_IDLE);
  assign brk_again = frame_end && cur_brk && brk_req;
  assign to_recov  = frame_end && cur_brk && !brk_req;
  assign take      = hold_valid && (idle_go || recov_end || (frame_end && !cur_brk));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '1;
      par_q   <= 1'b0;
      cur_brk <= 1'b0;
    end else if (bit_en) begin
      if (take) begin
        st      <= ST_START;
        shreg   <= hold_data;
        par_q   <= ^hold_data;
        cur_brk <= hold_brk;
        cnt     <= '0;
      end else if (brk_again) begin
        st  <= ST_START;
        cnt <= '0;
      end else if (to_recov) begin
        st      <= ST_RECOV;
        cnt     <= '0;
        cur_brk <= 1'b0;
      end else if (frame_end || recov_end) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          ST_START: begin
            st  <= ST_DATA;
            cnt <= '0;
          end
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (data_last) begin
              st  <= par_en ? ST_PAR : ST_STOP;
              cnt <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_PAR: st <= ST_STOP;
          ST_STOP: begin
            st  <= ST_GUARD;
            cnt <= '0;
          end
          ST_GUARD: cnt <= cnt + CNT_W'(1);
          ST_RECOV: cnt <= cnt + CNT_W'(1);
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0] && !cur_brk;
      ST_PAR:   txd = par_q && !cur_brk;
      ST_STOP:  txd = !cur_brk;
      ST_GUARD: txd = !cur_brk;
      default:  txd = 1'b1;
    endcase
  end

  assign busy     = (st != ST_IDLE);
  assign in_recov = (st == ST_RECOV);
  assign in_brk   = cur_brk && (st != ST_IDLE) && (st != ST_RECOV);

  p_brk_chain_r9: assert property (@(posedge clk) disable iff (rst)
    brk_again |=> (st == ST_START && cur_brk));

  p_recov_entry_r10: assert property (@(posedge clk) disable iff (rst)
    to_recov |=> (st == ST_RECOV && cnt == '0));

  p_recov_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECOV && bit_en && cnt < gap_ext - CNT_W'(1)) |=> (st == ST_RECOV));

  p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> (st == ST_START && !txd));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int DATA_W  = 8,
  parameter int TG_W    = 8,
  parameter int MIN_GAP = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_data,
  input  logic              par_en,
  input  logic [TG_W-1:0]   tg_len,
  input  logic              brk_start,
  input  logic              brk_stop,
  output logic              txd,
  output logic              txrdy,
  output logic              txempty
);

  logic              take;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              hold_brk;
  logic              brk_req;
  logic              busy;
  logic              in_recov;
  logic              in_brk;

  uart_brk_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .thr_wr     (thr_wr),
    .thr_data   (thr_data),
    .brk_start  (brk_start),
    .brk_stop   (brk_stop),
    .take       (take),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .hold_brk   (hold_brk),
    .brk_req    (brk_req)
  );

  uart_brk_shift #(
    .DATA_W  (DATA_W),
    .TG_W    (TG_W),
    .MIN_GAP (MIN_GAP)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .par_en     (par_en),
    .tg_len     (tg_len),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .hold_brk   (hold_brk),
    .brk_req    (brk_req),
    .take       (take),
    .txd        (txd),
    .busy       (busy),
    .in_recov   (in_recov),
    .in_brk     (in_brk)
  );

  assign txrdy   = !hold_valid;
  assign txempty = !hold_valid && !busy;

  p_empty_idle_r12: assert property (@(posedge clk) disable iff (rst)
    txempty |-> (txrdy && txd));

  p_recov_line_r10: assert property (@(posedge clk) disable iff (rst)
    in_recov |-> (txd && !txempty));

  p_brk_line_r9: assert property (@(posedge clk) disable iff (rst)
    in_brk |-> !txd);

  p_busy_rdy_r7: assert property (@(posedge clk) disable iff (rst)
    (!txrdy && brk_start && !take) |=> !txrdy);

endmodule

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       thr_wr = 1'b0;
  logic [7:0] thr_data = '0;
  logic       par_en = 1'b0;
  logic [7:0] tg_len = '0;
  logic       brk_start = 1'b0;
  logic       brk_stop = 1'b0;
  logic       txd;
  logic       txrdy;
  logic       txempty;

  int n_chk = 0;
  int n_bad = 0;
  bit run = 1'b0;
  int ph = 0;

  localparam int LOGN = 2048;
  logic lg [0:LOGN-1];
  int   lp = 0;

  uart_brk_tx u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .thr_wr(thr_wr), .thr_data(thr_data),
    .par_en(par_en), .tg_len(tg_len), .brk_start(brk_start), .brk_stop(brk_stop),
    .txd(txd), .txrdy(txrdy), .txempty(txempty)
  );

  always #5 clk = ~clk;

  // Bit-rate enable every 4 clocks; log the line value of each bit period
  always @(negedge clk) begin
    if (bit_en && lp < LOGN) begin
      lg[lp] = txd;
      lp++;
    end
    ph = (ph + 1) % 4;
    bit_en = run && (ph == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    thr_wr = 1'b1; thr_data = d;
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); brk_stop = 1'b1;
    @(negedge clk); brk_stop = 1'b0;
  endtask

  task automatic wait_rdy(input string tag);
    int t = 0;
    while (!txrdy && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, tag, t, 0);
  endtask

  task automatic wait_empty(input string tag);
    int t = 0;
    while (!txempty && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, tag, t, 0);
    wait_bits(3);
  endtask

  function automatic int find_zero(input int from);
    for (int i = from; i < lp; i++) if (lg[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic int run_len(input int from, input logic v);
    int n = 0;
    for (int i = from; i < lp; i++) begin
      if (lg[i] != v) break;
      n++;
    end
    return n;
  endfunction

  // Checks one normal frame starting at index s; returns index after guard
  task automatic chk_frame(input int s, input logic [7:0] d, input bit par,
                           input int tg, input string tag, output int nxt);
    logic [7:0] got;
    int p;
    chk(s >= 0 && lg[s] == 1'b0, {tag, " R3 start"}, s, 0);
    for (int k = 0; k < 8; k++) got[k] = lg[s + 1 + k];
    chk(got == d, {tag, " R3 data"}, got, d);
    p = s + 9;
    if (par) begin
      chk(lg[p] == ^d, {tag, " R4 parity"}, lg[p], ^d);
      p++;
    end
    chk(lg[p] == 1'b1, {tag, " R3 stop"}, lg[p], 1);
    p++;
    for (int g = 0; g < tg; g++)
      chk(lg[p + g] == 1'b1, {tag, " R5 guard"}, lg[p + g], 1);
    nxt = p + tg;
  endtask

  task automatic chk_quiet(input int from, input string tag);
    int z = find_zero(from);
    chk(z < 0, tag, z, -1);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(txrdy == 1'b1, "R1 txrdy", txrdy, 1);
    chk(txempty == 1'b1, "R1 txempty", txempty, 1);
  endtask

  task automatic t_basic();
    int l0, s, nx;
    par_en = 0; tg_len = 0;
    l0 = lp;
    wr(8'hA5);
    chk(txrdy == 1'b0, "R2 txrdy low", txrdy, 0);
    chk(txempty == 1'b0, "R2 txempty low", txempty, 0);
    wait_rdy("R2 load");
    chk(txempty == 1'b0, "R12 empty while shifting", txempty, 0);
    wait_empty("R12 basic");
    s = find_zero(l0);
    chk_frame(s, 8'hA5, 0, 0, "basic", nx);
    chk_quiet(nx, "R3 idle high after frame");
  endtask

  task automatic t_parity();
    int l0, s, nx, nx2;
    par_en = 1; tg_len = 0;
    l0 = lp;
    wr(8'h07);
    wait_rdy("R4 load");
    wr(8'h03);
    wait_empty("R4 empty");
    s = find_zero(l0);
    chk_frame(s, 8'h07, 1, 0, "par1", nx);
    chk(nx == s + 11, "R4 frame length", nx - s, 11);
    chk_frame(nx, 8'h03, 1, 0, "par0", nx2);
    par_en = 0;
  endtask

  task automatic t_guard_overrun();
    int l0, s, nx, nx2;
    par_en = 0; tg_len = 3;
    l0 = lp;
    wr(8'h3C);
    wait_rdy("R5 load");
    wr(8'hC3);
    chk(txrdy == 1'b0, "R6 full", txrdy, 0);
    wr(8'hFF);
    wait_empty("R5 empty");
    s = find_zero(l0);
    chk_frame(s, 8'h3C, 0, 3, "guard1", nx);
    chk(lg[s + 13] == 1'b0, "R5 next start position", lg[s + 13], 0);
    chk_frame(nx, 8'hC3, 0, 3, "guard2", nx2);
    chk_quiet(nx2, "R6 discarded byte absent");
  endtask

  task automatic t_break_min();
    int l0, s, z, e, o, nx;
    int t = 0;
    par_en = 0; tg_len = 0;
    l0 = lp;
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
    chk(txrdy == 1'b0, "R8 txrdy low", txrdy, 0);
    chk(txempty == 1'b0, "R8 txempty low", txempty, 0);
    thr_wr = 1'b1; thr_data = 8'h55;
    @(negedge clk); thr_wr = 1'b0;
    wait_bits(35);
    pulse_stop();
    while (txd == 1'b0 && t < 5000) begin @(negedge clk); t++; end
    wait_bits(5);
    chk(txempty == 1'b0, "R12 empty low in recovery", txempty, 0);
    chk(txrdy == 1'b1, "R7 rdy during recovery", txrdy, 1);
    wr(8'h42);
    wait_empty("R10 empty");
    s = find_zero(l0);
    z = run_len(s, 1'b0);
    chk(z % 10 == 0 && z >= 30, "R9 break run whole frames", z, 40);
    e = s + z;
    o = run_len(e, 1'b1);
    chk(o == 12, "R10 gap floor", o, 12);
    chk_frame(e + o, 8'h42, 0, 0, "after break", nx);
    chk_quiet(nx, "R11 byte written before break start absent");
  endtask

  task automatic t_break_guard();
    int l0, s, z, e, o, nx;
    par_en = 1; tg_len = 15;
    l0 = lp;
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
    wait_bits(60);
    chk(txd == 1'b0, "R9 line low mid break", txd, 0);
    wr(8'h81);
    pulse_stop();
    wait_empty("R10 guard empty");
    s = find_zero(l0);
    z = run_len(s, 1'b0);
    chk(z % 26 == 0 && z >= 52, "R9 break run with guard", z, 78);
    e = s + z;
    o = run_len(e, 1'b1);
    chk(o == 15, "R10 gap from guard", o, 15);
    chk_frame(e + o, 8'h81, 1, 15, "queued after break", nx);
    par_en = 0; tg_len = 0;
  endtask

  task automatic t_brk_ignored();
    int l0, s, nx, nx2;
    par_en = 0; tg_len = 0;
    l0 = lp;
    wr(8'h11);
    wait_rdy("R7 load");
    wr(8'h22);
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
    wait_empty("R7 empty");
    s = find_zero(l0);
    chk_frame(s, 8'h11, 0, 0, "R7 first", nx);
    chk_frame(nx, 8'h22, 0, 0, "R7 second", nx2);
    chk_quiet(nx2, "R7 no break on line");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    run = 1'b1;
    wait_bits(3);
    t_basic();
    t_parity();
    t_guard_overrun();
    t_break_min();
    t_break_guard();
    t_brk_ignored();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule